// File: doc/BRIEF.md
# Integer Divide Unit with Condition Flags

This block performs integer division for a processor datapath, signed or unsigned, in three operand forms. The word form divides a 32-bit dividend by a 16-bit divisor and returns one register value with the remainder in the upper half and the quotient in the lower half. The long form divides 32 bits by 32 bits. The wide form divides a 64-bit dividend, taken from a register pair, by 32 bits. The division is a radix-2 restoring loop on magnitudes with a sign fix-up at the end. Quotients truncate toward zero and a remainder carries the sign of the dividend.

The unit computes the N, Z, V and C condition flags and reports a divide-by-zero trap. It also supplies write enables and write data for the quotient and remainder destinations. The surrounding pipeline keeps the register file, decodes the instruction and builds any trap frame. A caller pulses `start` while the unit is idle. All operands, the form, the signedness, the destination-alias hint and the current N/Z/V flags are captured on that edge. The caller then waits for the one-cycle `done` pulse.

Top module: `intdiv_unit`

## Requirements
- R1: `flag_c` is 0 after every completion, including divide-by-zero and overflow completions.
- R2: A divisor of zero, judged on the divisor bits the form uses (low 16 in word form), gives `done` one cycle after the start edge. It also gives `dz_trap`=1, no write enable, and N/Z/V equal to the captured `n_in`/`z_in`/`v_in`.
- R3: Word form (`form`=0) produces one write: `q_wr_data`[31:16] holds the remainder and `q_wr_data`[15:0] the quotient, and `r_wr_en` stays 0. Only `divisor`[15:0] is used, sign-extended when signed.
- R4: Word form overflows when the unsigned quotient exceeds 0xFFFF, or when the signed quotient lies outside -32768..32767.
- R5: On overflow `flag_v`=1, `flag_z`=0, `flag_n` equals the captured `n_in`, and neither write enable is raised.
- R6: Without overflow `flag_v`=0 and N/Z describe the quotient: its bit 15 and its low 16 bits in word form, its bit 31 and all 32 bits in the long and wide forms.
- R7: Wide form (`form`=2) divides {`dvd_hi`,`dvd_lo`} and overflows when the quotient does not fit 32 bits, either unsigned or two's-complement as selected.
- R8: Long and wide forms (`form`=1, 2) write the quotient through `q_wr_*` and the remainder through `r_wr_*`. When `same_dest`=1 only the quotient is written.
- R9: Signed results truncate toward zero, and the remainder takes the sign of the dividend.
- R10: Handshake. After reset `busy`, `done` and the enables are 0. `busy` is 1 from the start edge until completion, and `done` lasts one cycle. A `start` while busy is ignored, and operand changes after the start edge have no effect.
- R11: With a nonzero divisor, `done` rises 33 cycles after the start edge for word and long forms and 65 cycles after it for the wide form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a division when idle |
| form | input | 2 | 0 word, 1 long, 2 wide |
| is_signed | input | 1 | Two's-complement operands |
| dvd_hi | input | 32 | Dividend upper word (wide form only) |
| dvd_lo | input | 32 | Dividend lower word |
| divisor | input | 32 | Divisor (low 16 bits in word form) |
| same_dest | input | 1 | Quotient and remainder share a destination |
| n_in | input | 1 | Current N flag |
| z_in | input | 1 | Current Z flag |
| v_in | input | 1 | Current V flag |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| dz_trap | output | 1 | Divide-by-zero trap for the last operation |
| flag_n | output | 1 | Resulting N |
| flag_z | output | 1 | Resulting Z |
| flag_v | output | 1 | Resulting V |
| flag_c | output | 1 | Resulting C |
| q_wr_en | output | 1 | Quotient destination write strobe |
| q_wr_data | output | 32 | Quotient (or packed word result) |
| r_wr_en | output | 1 | Remainder destination write strobe |
| r_wr_data | output | 32 | Remainder |

## Verification
The assertions assume that reset is applied before the first `start`. They also assume that a divisor reaching the iteration loop is nonzero, since the zero case is diverted before the loop and the remainder-below-divisor property relies on this. The stimulus pulses `start` for single cycles, away from the clock edge, and only when `busy` is low. The one exception is a deliberate re-start during busy, which tests that it is ignored. The zero-divisor cases include a word-form divisor whose upper half is nonzero but whose used half is zero.

// File: rtl/intdiv_pkg.sv
// Shared encodings for the integer divide unit.
// Assumes: form codes are fixed by the instruction decoder that drives the unit.
package intdiv_pkg;
    typedef enum logic [1:0] {
        DIV_WORD = 2'd0,
        DIV_LONG = 2'd1,
        DIV_QUAD = 2'd2
    } div_form_e;
endpackage

// File: rtl/intdiv_prep.sv
// Operand conditioning: extends the dividend and divisor per form and
// signedness, forms their magnitudes and the result signs.
// Assumes: W is even; form code 3 is handled like the long form.
module intdiv_prep
    import intdiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [1:0]     form,
    input  logic           sgn,
    input  logic [W-1:0]   dvd_hi,
    input  logic [W-1:0]   dvd_lo,
    input  logic [W-1:0]   dvs,
    output logic [2*W-1:0] dvd_mag,
    output logic [W-1:0]   dvs_mag,
    output logic           dvs_zero,
    output logic           q_neg,
    output logic           r_neg,
    output logic           wide
);
    localparam int DW = 2 * W;
    localparam int H  = W / 2;

    logic           is_word;
    logic [W-1:0]   dvs_ext;
    logic [DW-1:0]  dvd_ext;
    logic           dvd_neg;
    logic           dvs_neg;

    // Sign or zero extension of both operands, then magnitude and sign split.
    always_comb begin
        is_word = (form == DIV_WORD);
        wide    = (form == DIV_QUAD);
        if (is_word)
            dvs_ext = sgn ? {{H{dvs[H-1]}}, dvs[H-1:0]} : {{H{1'b0}}, dvs[H-1:0]};
        else
            dvs_ext = dvs;
        if (wide)
            dvd_ext = {dvd_hi, dvd_lo};
        else
            dvd_ext = sgn ? {{W{dvd_lo[W-1]}}, dvd_lo} : {{W{1'b0}}, dvd_lo};
        dvd_neg  = sgn & dvd_ext[DW-1];
        dvs_neg  = sgn & dvs_ext[W-1];
        dvd_mag  = dvd_neg ? (~dvd_ext + DW'(1)) : dvd_ext;
        dvs_mag  = dvs_neg ? (~dvs_ext + W'(1)) : dvs_ext;
        dvs_zero = (dvs_ext == '0);
        q_neg    = dvd_neg ^ dvs_neg;
        r_neg    = dvd_neg;
    end
endmodule

// File: rtl/intdiv_core.sv
// Radix-2 restoring divider on unsigned magnitudes. One quotient bit per
// cycle: W cycles for a single-width dividend, 2*W for a double-width one.
// Assumes: load is only raised with a nonzero divisor and while idle.
module intdiv_core #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           wide,
    input  logic [2*W-1:0] dvd_mag,
    input  logic [W-1:0]   dvs_mag,
    output logic           running,
    output logic           fin,
    output logic [2*W-1:0] quo,
    output logic [W-1:0]   rem
);
    localparam int DW = 2 * W;
    localparam int CW = $clog2(DW) + 1;

    logic          run_q;
    logic          fin_q;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] quo_q;
    logic [W-1:0]  rem_q;
    logic [W-1:0]  dvs_q;
    logic [W:0]    trial;
    logic [W+1:0]  diff;
    logic          fits;

    // Trial subtraction of the divisor from the shifted partial remainder.
    always_comb begin
        trial = {rem_q, quo_q[DW-1]};
        diff  = {1'b0, trial} - {2'b00, dvs_q};
        fits  = ~diff[W+1];
    end

    // Load, iterate and signal the last step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            fin_q <= 1'b0;
            cnt_q <= '0;
            quo_q <= '0;
            rem_q <= '0;
            dvs_q <= '0;
        end else begin
            fin_q <= 1'b0;
            if (load) begin
                run_q <= 1'b1;
                cnt_q <= wide ? CW'(DW) : CW'(W);
                quo_q <= wide ? dvd_mag : {dvd_mag[W-1:0], {W{1'b0}}};
                rem_q <= '0;
                dvs_q <= dvs_mag;
            end else if (run_q) begin
                rem_q <= fits ? diff[W-1:0] : trial[W-1:0];
                quo_q <= {quo_q[DW-2:0], fits};
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    run_q <= 1'b0;
                    fin_q <= 1'b1;
                end
            end
        end
    end

    assign running = run_q;
    assign fin     = fin_q;
    assign quo     = quo_q;
    assign rem     = rem_q;

    // R9: a finished partial remainder is always below the divisor.
    assert_rem_below_divisor_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fin_q |-> (rem_q < dvs_q));

    // R11: an active loop never sits at a zero step count.
    assert_count_live_R11: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q != '0));
endmodule

// File: rtl/intdiv_post.sv
// Result stage: applies signs, detects overflow per form, forms the flags
// and the destination writes.
// Assumes: quo/rem are magnitudes from the core; dz overrides everything.
module intdiv_post
    import intdiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [1:0]     form,
    input  logic           sgn,
    input  logic           q_neg,
    input  logic           r_neg,
    input  logic           dz,
    input  logic           same_dest,
    input  logic           n_in,
    input  logic           z_in,
    input  logic           v_in,
    input  logic [2*W-1:0] quo,
    input  logic [W-1:0]   rem,
    output logic           n_out,
    output logic           z_out,
    output logic           v_out,
    output logic           c_out,
    output logic           trap,
    output logic           ovf,
    output logic           q_we,
    output logic [W-1:0]   q_wd,
    output logic           r_we,
    output logic [W-1:0]   r_wd
);
    localparam int DW = 2 * W;
    localparam int H  = W / 2;
    localparam logic [DW-1:0] ONE   = {{(DW-1){1'b0}}, 1'b1};
    localparam logic [DW-1:0] H_LIM = ONE << (H - 1);
    localparam logic [DW-1:0] W_LIM = ONE << (W - 1);

    logic          is_word;
    logic [DW-1:0] q_val;
    logic [W-1:0]  r_val;
    logic [DW-1:0] lim;
    logic          big;

    // Signed values and the overflow decision for the selected form.
    always_comb begin
        is_word = (form == DIV_WORD);
        q_val   = q_neg ? (~quo + DW'(1)) : quo;
        r_val   = r_neg ? (~rem + W'(1)) : rem;
        lim     = is_word ? H_LIM : W_LIM;
        big     = is_word ? (|quo[DW-1:H]) : (|quo[DW-1:W]);
        ovf     = sgn ? (q_neg ? (quo > lim) : (quo >= lim)) : big;
    end

    // Flags and writes: trap first, then overflow, then a normal result.
    always_comb begin
        n_out = n_in;
        z_out = z_in;
        v_out = v_in;
        c_out = 1'b0;
        trap  = 1'b0;
        q_we  = 1'b0;
        q_wd  = '0;
        r_we  = 1'b0;
        r_wd  = '0;
        if (dz) begin
            trap = 1'b1;
        end else if (ovf) begin
            v_out = 1'b1;
            z_out = 1'b0;
        end else begin
            v_out = 1'b0;
            q_we  = 1'b1;
            if (is_word) begin
                n_out = q_val[H-1];
                z_out = (q_val[H-1:0] == '0);
                q_wd  = {r_val[H-1:0], q_val[H-1:0]};
            end else begin
                n_out = q_val[W-1];
                z_out = (q_val[W-1:0] == '0);
                q_wd  = q_val[W-1:0];
                r_we  = ~same_dest;
                r_wd  = r_val;
            end
        end
    end
endmodule

// File: rtl/intdiv_unit.sv
// Integer divide unit top: start/busy/done control, operand capture and
// registered results. Operands are sampled only on an accepted start.
// Assumes: synchronous active-low reset precedes the first start.
module intdiv_unit
    import intdiv_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        form,
    input  logic              is_signed,
    input  logic [DATA_W-1:0] dvd_hi,
    input  logic [DATA_W-1:0] dvd_lo,
    input  logic [DATA_W-1:0] divisor,
    input  logic              same_dest,
    input  logic              n_in,
    input  logic              z_in,
    input  logic              v_in,
    output logic              busy,
    output logic              done,
    output logic              dz_trap,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_c,
    output logic              q_wr_en,
    output logic [DATA_W-1:0] q_wr_data,
    output logic              r_wr_en,
    output logic [DATA_W-1:0] r_wr_data
);
    localparam int W  = DATA_W;
    localparam int DW = 2 * W;

    logic [DW-1:0] p_dvd_mag;
    logic [W-1:0]  p_dvs_mag;
    logic          p_dvs_zero, p_q_neg, p_r_neg, p_wide;

    logic          busy_q, zpend_q;
    logic [1:0]    form_q;
    logic          sgn_q, same_q, n_q, z_q, v_q, qneg_q, rneg_q;

    logic          accept, core_load, core_run, core_fin, finish;
    logic [DW-1:0] core_quo;
    logic [W-1:0]  core_rem;

    logic          o_n, o_z, o_v, o_c, o_trap, o_ovf, o_qwe, o_rwe;
    logic [W-1:0]  o_qwd, o_rwd;

    logic          done_q, trap_q, fn_q, fz_q, fv_q, fc_q, qwe_q, rwe_q;
    logic [W-1:0]  qwd_q, rwd_q;

    intdiv_prep #(.W(W)) u_prep (
        .form     (form),
        .sgn      (is_signed),
        .dvd_hi   (dvd_hi),
        .dvd_lo   (dvd_lo),
        .dvs      (divisor),
        .dvd_mag  (p_dvd_mag),
        .dvs_mag  (p_dvs_mag),
        .dvs_zero (p_dvs_zero),
        .q_neg    (p_q_neg),
        .r_neg    (p_r_neg),
        .wide     (p_wide)
    );

    assign accept    = start & ~busy_q;
    assign core_load = accept & ~p_dvs_zero;
    assign finish    = zpend_q | core_fin;

    intdiv_core #(.W(W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (core_load),
        .wide    (p_wide),
        .dvd_mag (p_dvd_mag),
        .dvs_mag (p_dvs_mag),
        .running (core_run),
        .fin     (core_fin),
        .quo     (core_quo),
        .rem     (core_rem)
    );

    // Capture the operation context on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            form_q <= 2'd0;
            sgn_q  <= 1'b0;
            same_q <= 1'b0;
            n_q    <= 1'b0;
            z_q    <= 1'b0;
            v_q    <= 1'b0;
            qneg_q <= 1'b0;
            rneg_q <= 1'b0;
        end else if (accept) begin
            form_q <= form;
            sgn_q  <= is_signed;
            same_q <= same_dest;
            n_q    <= n_in;
            z_q    <= z_in;
            v_q    <= v_in;
            qneg_q <= p_q_neg;
            rneg_q <= p_r_neg;
        end
    end

    // Busy window and the zero-divisor bypass of the iteration loop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            zpend_q <= 1'b0;
        end else if (accept) begin
            busy_q  <= 1'b1;
            zpend_q <= p_dvs_zero;
        end else if (finish) begin
            busy_q  <= 1'b0;
            zpend_q <= 1'b0;
        end
    end

    intdiv_post #(.W(W)) u_post (
        .form      (form_q),
        .sgn       (sgn_q),
        .q_neg     (qneg_q),
        .r_neg     (rneg_q),
        .dz        (zpend_q),
        .same_dest (same_q),
        .n_in      (n_q),
        .z_in      (z_q),
        .v_in      (v_q),
        .quo       (core_quo),
        .rem       (core_rem),
        .n_out     (o_n),
        .z_out     (o_z),
        .v_out     (o_v),
        .c_out     (o_c),
        .trap      (o_trap),
        .ovf       (o_ovf),
        .q_we      (o_qwe),
        .q_wd      (o_qwd),
        .r_we      (o_rwe),
        .r_wd      (o_rwd)
    );

    // Register results on completion; strobes pulse, values hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            trap_q <= 1'b0;
            fn_q   <= 1'b0;
            fz_q   <= 1'b0;
            fv_q   <= 1'b0;
            fc_q   <= 1'b0;
            qwe_q  <= 1'b0;
            rwe_q  <= 1'b0;
            qwd_q  <= '0;
            rwd_q  <= '0;
        end else begin
            done_q <= finish;
            qwe_q  <= finish & o_qwe;
            rwe_q  <= finish & o_rwe;
            if (finish) begin
                trap_q <= o_trap;
                fn_q   <= o_n;
                fz_q   <= o_z;
                fv_q   <= o_v;
                fc_q   <= o_c;
                qwd_q  <= o_qwd;
                rwd_q  <= o_rwd;
            end
        end
    end

    assign busy      = busy_q;
    assign done      = done_q;
    assign dz_trap   = trap_q;
    assign flag_n    = fn_q;
    assign flag_z    = fz_q;
    assign flag_v    = fv_q;
    assign flag_c    = fc_q;
    assign q_wr_en   = qwe_q;
    assign q_wr_data = qwd_q;
    assign r_wr_en   = rwe_q;
    assign r_wr_data = rwd_q;

    // R1: carry is clear at every completion.
    assert_carry_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !flag_c);

    // R2: a trap completion writes nothing.
    assert_trap_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dz_trap) |-> (!q_wr_en && !r_wr_en));

    // R3: the word form never raises the remainder strobe.
    assert_word_single_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && form_q == DIV_WORD) |-> !r_wr_en);

    // R5: an overflow completion clears Z and writes nothing.
    assert_no_overflow_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flag_v && !dz_trap) |-> (!flag_z && !q_wr_en && !r_wr_en));

    // R8: aliased destinations leave only the quotient strobe.
    assert_alias_quotient_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && same_q) |-> !r_wr_en);

    // R10: done is a single-cycle pulse outside the busy window.
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R11: the loop only runs inside the busy window.
    assert_loop_in_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        core_run |-> busy_q);
endmodule

// File: tb/intdiv_unit_test.sv
module intdiv_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  form = 2'd0;
    logic        is_signed = 1'b0;
    logic [31:0] dvd_hi = '0, dvd_lo = '0, divisor = '0;
    logic        same_dest = 1'b0, n_in = 1'b0, z_in = 1'b0, v_in = 1'b0;
    logic        busy, done, dz_trap, flag_n, flag_z, flag_v, flag_c;
    logic        q_wr_en, r_wr_en;
    logic [31:0] q_wr_data, r_wr_data;

    int vectors = 0;
    int fails = 0;

    // expected values from the behavioural model
    logic        e_dz, e_ovf, e_n, e_z, e_v, e_qwe, e_rwe;
    logic [31:0] e_qd, e_rd;
    int          e_lat;

    always #5 clk = ~clk;

    intdiv_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .form(form), .is_signed(is_signed),
        .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .divisor(divisor), .same_dest(same_dest),
        .n_in(n_in), .z_in(z_in), .v_in(v_in), .busy(busy), .done(done),
        .dz_trap(dz_trap), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v),
        .flag_c(flag_c), .q_wr_en(q_wr_en), .q_wr_data(q_wr_data),
        .r_wr_en(r_wr_en), .r_wr_data(r_wr_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    // Model of the requirements using wide signed arithmetic.
    task automatic model(input logic [1:0] f, input bit s, input logic [31:0] hi,
                         input logic [31:0] lo, input logic [31:0] d,
                         input bit same, input bit ni, input bit zi, input bit vi);
        logic signed [95:0] a, b, q, r;
        if (f == 2'd2) a = s ? {{32{hi[31]}}, hi, lo} : {32'b0, hi, lo};
        else           a = s ? {{64{lo[31]}}, lo} : {64'b0, lo};
        if (f == 2'd0) b = s ? {{80{d[15]}}, d[15:0]} : {80'b0, d[15:0]};
        else           b = s ? {{64{d[31]}}, d} : {64'b0, d};
        e_n = ni; e_z = zi; e_v = vi; e_qwe = 0; e_rwe = 0; e_qd = '0; e_rd = '0;
        e_dz = (b == 0); e_ovf = 0;
        e_lat = e_dz ? 1 : ((f == 2'd2) ? 65 : 33);
        if (!e_dz) begin
            q = a / b;
            r = a % b;
            if (f == 2'd0)
                e_ovf = s ? (q > 96'sd32767 || q < -96'sd32768) : (q > 96'sd65535);
            else
                e_ovf = s ? (q > 96'sd2147483647 || q < -96'sd2147483648)
                          : (q > 96'sd4294967295);
            if (e_ovf) begin
                e_v = 1; e_z = 0;
            end else begin
                e_v = 0; e_qwe = 1;
                if (f == 2'd0) begin
                    e_n = q[15]; e_z = (q[15:0] == 0);
                    e_qd = {r[15:0], q[15:0]};
                end else begin
                    e_n = q[31]; e_z = (q[31:0] == 0);
                    e_qd = q[31:0]; e_rwe = !same; e_rd = r[31:0];
                end
            end
        end
    endtask

    // Apply one division and compare every output; optional re-start while busy.
    task automatic do_op(input logic [1:0] f, input bit s, input logic [31:0] hi,
                         input logic [31:0] lo, input logic [31:0] d, input bit same,
                         input bit ni, input bit zi, input bit vi,
                         input string req, input bit disturb);
        int k;
        bit seen;
        model(f, s, hi, lo, d, same, ni, zi, vi);
        @(negedge clk);
        form = f; is_signed = s; dvd_hi = hi; dvd_lo = lo; divisor = d;
        same_dest = same; n_in = ni; z_in = zi; v_in = vi; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(busy === 1'b1, "R10", "busy after start", {63'b0, busy}, 64'd1);
        if (disturb) begin
            form = 2'd1; is_signed = ~s; dvd_lo = ~lo; divisor = d + 32'd3;
            same_dest = ~same; n_in = ~ni; start = 1'b1;
        end else begin
            start = 1'b0;
        end
        k = 0; seen = 0;
        for (int i = 0; i < 200 && !seen; i++) begin
            @(posedge clk);
            k++;
            @(negedge clk);
            start = 1'b0;
            if (done === 1'b1) seen = 1;
        end
        check(seen, req, "done seen", {63'b0, seen}, 64'd1);
        check(k == e_lat, e_dz ? "R2" : "R11", "latency", 64'(k), 64'(e_lat));
        check(flag_c === 1'b0, "R1", "flag_c", {63'b0, flag_c}, 64'd0);
        check(dz_trap === e_dz, "R2", "dz_trap", {63'b0, dz_trap}, {63'b0, e_dz});
        check(flag_v === e_v, req, "flag_v", {63'b0, flag_v}, {63'b0, e_v});
        check(flag_n === e_n, req, "flag_n", {63'b0, flag_n}, {63'b0, e_n});
        check(flag_z === e_z, req, "flag_z", {63'b0, flag_z}, {63'b0, e_z});
        check(q_wr_en === e_qwe, req, "q_wr_en", {63'b0, q_wr_en}, {63'b0, e_qwe});
        check(r_wr_en === e_rwe, req, "r_wr_en", {63'b0, r_wr_en}, {63'b0, e_rwe});
        if (e_qwe) check(q_wr_data === e_qd, req, "q_wr_data", {32'b0, q_wr_data}, {32'b0, e_qd});
        if (e_rwe) check(r_wr_data === e_rd, req, "r_wr_data", {32'b0, r_wr_data}, {32'b0, e_rd});
        @(negedge clk);
        check(done === 1'b0 && q_wr_en === 1'b0 && r_wr_en === 1'b0, "R10", "done pulse width",
              {61'b0, done, q_wr_en, r_wr_en}, 64'd0);
    endtask

    task automatic t_reset;
        check(busy === 0 && done === 0 && q_wr_en === 0 && r_wr_en === 0, "R10", "reset state",
              {60'b0, busy, done, q_wr_en, r_wr_en}, 64'd0);
    endtask

    task automatic t_word_unsigned;  // R3 R6
        do_op(2'd0, 0, 32'h0, 32'd100000, 32'd7, 0, 0, 0, 0, "R3", 0);
        do_op(2'd0, 0, 32'h0, 32'd0, 32'd5, 0, 1, 0, 0, "R6", 0);
        do_op(2'd0, 0, 32'h0, 32'h0001_FFFE, 32'hABCD_0002, 0, 0, 1, 1, "R4", 0);
    endtask

    task automatic t_word_signed;    // R9
        do_op(2'd0, 1, 32'h0, -32'sd100000, 32'd7, 0, 0, 0, 0, "R9", 0);
        do_op(2'd0, 1, 32'h0, 32'd100000, 32'h1234_FFF9, 0, 0, 0, 0, "R9", 0);
        do_op(2'd0, 1, 32'h0, -32'sd100000, 32'h0000_FFF9, 0, 1, 1, 0, "R9", 0);
    endtask

    task automatic t_word_overflow;  // R4 R5
        do_op(2'd0, 0, 32'h0, 32'h0001_0000, 32'd1, 0, 1, 1, 0, "R4", 0);
        do_op(2'd0, 1, 32'h0, 32'h0000_8000, 32'd1, 0, 0, 1, 0, "R5", 0);
        do_op(2'd0, 1, 32'h0, 32'hFFFF_8000, 32'h0000_FFFF, 0, 1, 0, 0, "R5", 0);
        do_op(2'd0, 1, 32'h0, 32'hFFFF_8000, 32'd1, 0, 0, 0, 1, "R4", 0);
    endtask

    task automatic t_long;           // R6 R8 R9 R5
        do_op(2'd1, 0, 32'h0, 32'hFFFF_FFFF, 32'h10, 0, 0, 0, 0, "R8", 0);
        do_op(2'd1, 1, 32'h0, -32'sd7, 32'd2, 1, 0, 0, 0, "R8", 0);
        do_op(2'd1, 1, 32'h0, -32'sd7, 32'd2, 0, 0, 0, 0, "R9", 0);
        do_op(2'd1, 1, 32'h0, 32'h8000_0000, 32'hFFFF_FFFF, 0, 1, 1, 0, "R5", 0);
        do_op(2'd1, 0, 32'h0, 32'h8000_0000, 32'hFFFF_FFFF, 0, 1, 0, 1, "R6", 0);
    endtask

    task automatic t_quad;           // R7
        do_op(2'd2, 0, 32'd1, 32'd0, 32'd2, 0, 0, 0, 0, "R7", 0);
        do_op(2'd2, 0, 32'd2, 32'd0, 32'd2, 0, 0, 1, 0, "R7", 0);
        do_op(2'd2, 1, 32'hFFFF_FFFF, 32'hFFFF_FFF9, 32'd2, 0, 0, 0, 0, "R7", 0);
        do_op(2'd2, 1, 32'h0, 32'h8000_0000, 32'd1, 0, 1, 0, 0, "R7", 0);
        do_op(2'd2, 1, 32'hFFFF_FFFF, 32'h8000_0000, 32'd1, 0, 0, 0, 0, "R7", 0);
        do_op(2'd2, 0, 32'h0000_0003, 32'h1234_5678, 32'd7, 1, 0, 0, 0, "R8", 0);
    endtask

    task automatic t_divzero;        // R2 R1
        do_op(2'd0, 0, 32'h0, 32'd1234, 32'hABCD_0000, 0, 1, 0, 1, "R2", 0);
        do_op(2'd1, 1, 32'h0, 32'd99, 32'd0, 0, 0, 1, 0, "R2", 0);
        do_op(2'd2, 0, 32'd5, 32'd6, 32'd0, 1, 1, 1, 1, "R2", 0);
    endtask

    task automatic t_busy_ignore;    // R10
        do_op(2'd0, 0, 32'h0, 32'd50000, 32'd9, 0, 0, 0, 0, "R10", 1);
        do_op(2'd2, 1, 32'hFFFF_FFFE, 32'h0000_0001, 32'hFFFF_FFFD, 0, 0, 0, 0, "R10", 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word_unsigned();
        t_word_signed();
        t_word_overflow();
        t_long();
        t_quad();
        t_divzero();
        t_busy_ignore();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule